// File: doc/BRIEF.md
# Parallel LCD Command/Data Bridge

This block connects a 32-bit register-mapped host port to a 16-bit parallel bus that drives up to two smart panels. Each panel has its own controller and frame memory. Host writes to the command, parameter or data slots become write cycles on the panel bus. A dedicated address line (A0) is low for commands and high for everything else. Host writes to either panel-read slot start a panel read cycle. The sampled halfword is held in a receive buffer that the host can read back afterwards.

Every panel cycle lasts a fixed number of clocks. While a cycle is in flight, the bridge holds off the host with a ready signal. A frame transfer is opened by a start request in the control register and is counted down by a pixel counter. Each data write and each panel read takes one from the counter. When the counter reaches zero, the busy flag drops and a one-clock frame-done pulse goes to the display controller. The host can store and read back the timing words for both chips, but the cycle length is set by a parameter and not by those words.

Top module: `lcd_cmd_bridge`

## Requirements
- R1: After reset, the control word reads 0, both configuration words read 0x00310000 and system status reads 0x1. Both chip selects and both strobes are high (inactive), host_ready is 1 and frame_done is 0.
- R2: Register widths:
  - Control keeps bits 3:0 only: bit 0 enable, bit 1 bypass, bit 2 selects chip 0, bit 3 selects chip 1.
  - The configuration words keep the bits in 0x003F1FFF.
  - The line-number word keeps 11 bits.
  - The on/off timing words keep 30 bits and the cycle timing words keep 28 bits.
- R3: A write to the command slot (address 3) starts one panel write cycle. The cycle carries host bits 15:0 with A0=0. pnl_cs_n[0] is low when chip 0 is selected and pnl_cs_n[1] is low when chip 1 is selected. Each cycle lasts CYCLE_LEN clocks, and pnl_we_n is low for the first CYCLE_LEN-1 of them.
- R4: A write to the parameter slot (address 4) starts one panel write cycle that carries bits 15:0 with A0=1.
- R5: A write to the data slot (address 5) starts two write cycles with A0=1. The first carries bits 15:0 and the second carries bits 31:16.
- R6: With neither chip selected, writes to the panel slots produce no panel activity.
- R7: A write to address 6 starts a panel read with A0=1, and a write to address 7 starts one with A0=0. pnl_re_n is low and only one chip is selected: chip 0 if it is enabled, otherwise chip 1. The sampled pnl_din is then read back at address 6 or 7.
- R8: host_ready is 0 while a panel cycle is in flight. Host accesses made while host_ready is 0 have no effect.
- R9: A control write with bit 4 set opens a transfer (system status bit 8 = busy) only when all of the following hold:
  - the written enable bit is 1;
  - the written bypass bit is 0;
  - the bridge is not already busy;
  - configuration 0 and configuration 1 share no set bit in positions 3:2.
- R10: Data-slot writes and panel-read writes each decrement a nonzero pixel count (address 1). The access that takes the count to zero clears busy and, if busy was set, pulses frame_done for exactly one clock.
- R11: System status (address 8) always reads bit 0 as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_req | input | 1 | Host access request |
| host_we | input | 1 | Host write when 1 |
| host_addr | input | 4 | Word address of the register |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Register read data (combinational) |
| host_ready | output | 1 | Bridge can accept an access |
| pnl_cs_n | output | 2 | Chip selects, bit 0 for chip 0, active low |
| pnl_we_n | output | 1 | Panel write strobe, active low |
| pnl_re_n | output | 1 | Panel read strobe, active low |
| pnl_a0 | output | 1 | 0 for command or status, 1 for data |
| pnl_dout | output | 16 | Panel write data |
| pnl_din | input | 16 | Panel read data |
| frame_done | output | 1 | One-clock pulse when a transfer ends |

## Verification
The hardest situation to reach from the ports is a host access that arrives in the middle of a panel cycle. A normal host never issues one, because it waits for host_ready. To create it, the bench starts a two-halfword data write and, on the next clock, forces a line-number write onto the bus while host_ready is low. It then reads that register back after the panel goes idle. Start gating is reached by loading configuration words that do and do not overlap in bits 3:2. The end of a transfer is reached by mixing data writes and panel reads against a small pixel count.

// File: rtl/lcd_cmd_bridge.sv
module lcd_cmd_bridge #(
  parameter int CYCLE_LEN = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_req,
  input  logic        host_we,
  input  logic [3:0]  host_addr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        host_ready,
  output logic [1:0]  pnl_cs_n,
  output logic        pnl_we_n,
  output logic        pnl_re_n,
  output logic        pnl_a0,
  output logic [15:0] pnl_dout,
  input  logic [15:0] pnl_din,
  output logic        frame_done
);
  localparam int CW = (CYCLE_LEN > 1) ? $clog2(CYCLE_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLE_LEN - 1);
  localparam logic [CW-1:0] SAMPLE = CW'(CYCLE_LEN - 2);
  localparam logic [31:0] CFG_KEEP = 32'h003F1FFF;
  localparam logic [31:0] CFG_INIT = 32'h00310000;
  localparam logic [3:0] A_CTRL = 4'd0, A_PIX = 4'd1, A_LINE = 4'd2, A_CMD = 4'd3,
                         A_PARM = 4'd4, A_DATA = 4'd5, A_RDD = 4'd6, A_RDS = 4'd7,
                         A_SYS = 4'd8, A_CFG0 = 4'd9, A_CFG1 = 4'd10, A_ON0 = 4'd11,
                         A_CY0 = 4'd12, A_ON1 = 4'd13, A_CY1 = 4'd14;

  logic [3:0]  ctrl;
  logic [31:0] pixcnt, cfg0, cfg1;
  logic [10:0] line_q;
  logic [29:0] on0, on1;
  logic [27:0] cy0, cy1;
  logic [15:0] rxbuf, hold, dout_q;
  logic        busy, fdone;
  logic        act, rd, a0_q, second;
  logic [CW-1:0] cnt;
  logic [1:0]  csm;

  wire [1:0] sel     = ctrl[3:2];
  wire [1:0] rd_mask = sel[0] ? 2'b01 : (sel[1] ? 2'b10 : 2'b00);
  wire       wr      = host_req && host_ready && host_we;
  wire       is_w    = wr && (host_addr == A_CMD || host_addr == A_PARM || host_addr == A_DATA) && sel != 2'b00;
  wire       is_r    = wr && (host_addr == A_RDD || host_addr == A_RDS) && sel != 2'b00;
  wire       counts  = wr && (host_addr == A_DATA || host_addr == A_RDD || host_addr == A_RDS);
  wire       start   = wr && host_addr == A_CTRL && host_wdata[4] && host_wdata[0] && !host_wdata[1]
                       && !busy && ((cfg0 & cfg1 & 32'hC) == 32'h0);
  wire       strobe  = act && cnt != LAST;

  assign host_ready = !act;
  assign pnl_cs_n   = act ? ~csm : 2'b11;
  assign pnl_we_n   = ~(strobe && !rd);
  assign pnl_re_n   = ~(strobe && rd);
  assign pnl_a0     = a0_q;
  assign pnl_dout   = dout_q;
  assign frame_done = fdone;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0; pixcnt <= '0; line_q <= '0; cfg0 <= CFG_INIT; cfg1 <= CFG_INIT;
      on0 <= '0; on1 <= '0; cy0 <= '0; cy1 <= '0; busy <= 1'b0; fdone <= 1'b0;
    end else begin
      fdone <= 1'b0;
      if (wr) begin
        case (host_addr)
          A_CTRL: ctrl   <= host_wdata[3:0];
          A_PIX:  pixcnt <= host_wdata;
          A_LINE: line_q <= host_wdata[10:0];
          A_CFG0: cfg0   <= host_wdata & CFG_KEEP;
          A_CFG1: cfg1   <= host_wdata & CFG_KEEP;
          A_ON0:  on0    <= host_wdata[29:0];
          A_CY0:  cy0    <= host_wdata[27:0];
          A_ON1:  on1    <= host_wdata[29:0];
          A_CY1:  cy1    <= host_wdata[27:0];
          default: ;
        endcase
      end
      if (start) busy <= 1'b1;
      if (counts && pixcnt != 32'd0) begin
        pixcnt <= pixcnt - 32'd1;
        if (pixcnt == 32'd1) begin
          busy  <= 1'b0;
          fdone <= busy;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act <= 1'b0; rd <= 1'b0; a0_q <= 1'b0; second <= 1'b0; cnt <= '0;
      csm <= '0; dout_q <= '0; hold <= '0; rxbuf <= '0;
    end else if (!act) begin
      if (is_w || is_r) begin
        act    <= 1'b1;
        cnt    <= '0;
        rd     <= is_r;
        csm    <= is_r ? rd_mask : sel;
        a0_q   <= !(host_addr == A_CMD || host_addr == A_RDS);
        dout_q <= host_wdata[15:0];
        hold   <= host_wdata[31:16];
        second <= host_addr == A_DATA;
      end
    end else begin
      if (rd && cnt == SAMPLE) rxbuf <= pnl_din;
      if (cnt == LAST) begin
        if (second) begin
          second <= 1'b0;
          cnt    <= '0;
          dout_q <= hold;
        end else begin
          act <= 1'b0;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_comb begin
    case (host_addr)
      A_CTRL:        host_rdata = {28'd0, ctrl};
      A_PIX:         host_rdata = pixcnt;
      A_LINE:        host_rdata = {21'd0, line_q};
      A_RDD, A_RDS:  host_rdata = {16'd0, rxbuf};
      A_SYS:         host_rdata = {23'd0, busy, 7'd0, 1'b1};
      A_CFG0:        host_rdata = cfg0;
      A_CFG1:        host_rdata = cfg1;
      A_ON0:         host_rdata = {2'd0, on0};
      A_CY0:         host_rdata = {4'd0, cy0};
      A_ON1:         host_rdata = {2'd0, on1};
      A_CY1:         host_rdata = {4'd0, cy1};
      default:       host_rdata = 32'd0;
    endcase
  end

  p_strobe_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !pnl_we_n |-> pnl_cs_n != 2'b11);
  p_read_one_chip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !pnl_re_n |-> $countones(~pnl_cs_n) == 1);
  p_hold_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && host_ready && host_we && host_addr == A_DATA && ctrl[3:2] != 2'b00) |=> !host_ready);
  p_idle_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready |-> (pnl_cs_n == 2'b11 && pnl_we_n && pnl_re_n));
  p_fd_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);
  p_fd_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !busy);
endmodule

// File: tb/lcd_cmd_bridge_tb_top.sv
module lcd_cmd_bridge_tb_top;
  localparam int CL = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic host_req = 1'b0, host_we = 1'b0;
  logic [3:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic host_ready, pnl_we_n, pnl_re_n, pnl_a0, frame_done;
  logic [1:0] pnl_cs_n;
  logic [15:0] pnl_dout;
  logic [15:0] pnl_din = '0;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lcd_cmd_bridge #(.CYCLE_LEN(CL)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_ready(host_ready), .pnl_cs_n(pnl_cs_n), .pnl_we_n(pnl_we_n),
    .pnl_re_n(pnl_re_n), .pnl_a0(pnl_a0), .pnl_dout(pnl_dout),
    .pnl_din(pnl_din), .frame_done(frame_done));

  // sel[1:0], addr, wdata, n events, a0/data of first, a0/data of second
  localparam logic [73:0] VEC [0:5] = '{
    {2'b01, 4'd3, 32'hAAAA1234, 2'd1, 1'b0, 16'h1234, 1'b0, 16'h0000},
    {2'b10, 4'd4, 32'h0000BEEF, 2'd1, 1'b1, 16'hBEEF, 1'b0, 16'h0000},
    {2'b11, 4'd5, 32'h5678CAFE, 2'd2, 1'b1, 16'hCAFE, 1'b1, 16'h5678},
    {2'b00, 4'd3, 32'h00001111, 2'd0, 1'b0, 16'h0000, 1'b0, 16'h0000},
    {2'b01, 4'd5, 32'hFFFF0000, 2'd2, 1'b1, 16'h0000, 1'b1, 16'hFFFF},
    {2'b11, 4'd3, 32'h000000C3, 2'd1, 1'b0, 16'h00C3, 1'b0, 16'h0000}
  };

  logic [1:0]  ev_cs [0:63];
  logic        ev_a0 [0:63];
  logic [15:0] ev_d  [0:63];
  int nev = 0, nrev = 0, fd_cnt = 0, lowlen = 0, badlen = 0;
  logic [1:0] rcs;
  logic ra0;
  logic prev_we = 1'b1, prev_re = 1'b1;

  always @(negedge clk) begin
    if (!pnl_we_n && prev_we && nev < 64) begin
      ev_cs[nev] = pnl_cs_n; ev_a0[nev] = pnl_a0; ev_d[nev] = pnl_dout; nev++;
    end
    if (!pnl_re_n && prev_re) begin rcs = pnl_cs_n; ra0 = pnl_a0; nrev++; end
    if (!pnl_we_n) lowlen++;
    else if (!prev_we) begin
      if (lowlen != CL - 1) badlen++;
      lowlen = 0;
    end
    if (frame_done) fd_cnt++;
    prev_we = pnl_we_n; prev_re = pnl_re_n;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    while (!host_ready) @(negedge clk);
    host_addr = a; host_wdata = d; host_req = 1'b1; host_we = 1'b1;
    @(negedge clk);
    host_req = 1'b0; host_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!host_ready) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int base, fd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(pnl_cs_n == 2'b11 && pnl_we_n && pnl_re_n, "R1 panel idle", {29'd0, pnl_cs_n, pnl_we_n}, 32'h7);
    check(host_ready && !frame_done, "R1 ready", {30'd0, host_ready, frame_done}, 32'h2);
    rd(4'd0, r); check(r == 32'h0, "R1 ctrl", r, 32'h0);
    rd(4'd9, r); check(r == 32'h00310000, "R1 cfg0", r, 32'h00310000);
    rd(4'd10, r); check(r == 32'h00310000, "R1 cfg1", r, 32'h00310000);
    rd(4'd8, r); check(r == 32'h1, "R1 R11 sysstat", r, 32'h1);

    // table of panel write vectors: R3 R4 R5 R6
    for (int i = 0; i < 6; i++) begin
      logic [73:0] v;
      v = VEC[i];
      base = nev;
      wr(4'd0, {28'd0, v[73:72], 2'b00});
      wr(v[71:68], v[67:36]);
      wait_idle();
      check(nev - base == int'(v[35:34]), "R3 R5 R6 cycle count", nev - base, {30'd0, v[35:34]});
      if (v[35:34] >= 2'd1 && nev - base >= 1) begin
        check(ev_cs[base] == ~v[73:72], "R3 chip selects", {30'd0, ev_cs[base]}, {30'd0, ~v[73:72]});
        check(ev_a0[base] == v[33] && ev_d[base] == v[32:17], "R3 R4 first halfword",
              {15'd0, ev_a0[base], ev_d[base]}, {15'd0, v[33], v[32:17]});
      end
      if (v[35:34] == 2'd2 && nev - base >= 2)
        check(ev_a0[base+1] == v[16] && ev_d[base+1] == v[15:0], "R5 second halfword",
              {15'd0, ev_a0[base+1], ev_d[base+1]}, {15'd0, v[16], v[15:0]});
    end
    check(badlen == 0, "R3 strobe length", badlen, 0);

    // R2 register widths, bypass blocks start (R9)
    wr(4'd0, 32'hFFFFFFFF);
    rd(4'd0, r); check(r == 32'hF, "R2 ctrl bits", r, 32'hF);
    rd(4'd8, r); check(r == 32'h1, "R9 bypass blocks start", r, 32'h1);
    wr(4'd9, 32'hFFFFFFFF);
    rd(4'd9, r); check(r == 32'h003F1FFF, "R2 cfg0 mask", r, 32'h003F1FFF);
    wr(4'd2, 32'hFFFFFFFF);
    rd(4'd2, r); check(r == 32'h7FF, "R2 line", r, 32'h7FF);
    wr(4'd11, 32'hFFFFFFFF);
    rd(4'd11, r); check(r == 32'h3FFFFFFF, "R2 on/off", r, 32'h3FFFFFFF);
    wr(4'd14, 32'hFFFFFFFF);
    rd(4'd14, r); check(r == 32'h0FFFFFFF, "R2 cycle time", r, 32'h0FFFFFFF);
    wr(4'd9, 32'h00310000);
    wr(4'd0, 32'h0);

    // R8 access during a cycle ignored
    wr(4'd0, 32'h4);
    wr(4'd2, 32'h5);
    wr(4'd5, 32'h22221111);
    check(!host_ready, "R8 ready low", {31'd0, host_ready}, 32'h0);
    host_addr = 4'd2; host_wdata = 32'h123; host_req = 1'b1; host_we = 1'b1;
    @(negedge clk);
    host_req = 1'b0; host_we = 1'b0;
    wait_idle();
    rd(4'd2, r); check(r == 32'h5, "R8 ignored write", r, 32'h5);

    // R7 panel reads
    pnl_din = 16'h9A5C;
    base = nrev;
    wr(4'd0, 32'hC);
    wr(4'd6, 32'h0);
    wait_idle();
    check(nrev - base == 1 && rcs == 2'b10 && ra0 == 1'b1, "R7 data read chip0 priority",
          {29'd0, rcs, ra0}, 32'h5);
    rd(4'd6, r); check(r == 32'h9A5C, "R7 rxbuf", r, 32'h9A5C);
    pnl_din = 16'h0042;
    wr(4'd0, 32'h8);
    wr(4'd7, 32'h0);
    wait_idle();
    check(rcs == 2'b01 && ra0 == 1'b0, "R7 status read chip1", {29'd0, rcs, ra0}, 32'h2);
    rd(4'd7, r); check(r == 32'h42, "R7 rxbuf status", r, 32'h42);

    // R9 R10 transfer
    fd0 = fd_cnt;
    wr(4'd1, 32'd2);
    wr(4'd0, 32'h15);
    rd(4'd8, r); check(r == 32'h101, "R9 start busy", r, 32'h101);
    rd(4'd0, r); check(r == 32'h5, "R2 start bit not stored", r, 32'h5);
    wr(4'd0, 32'h15);
    wr(4'd5, 32'h00020001);
    wait_idle();
    rd(4'd1, r); check(r == 32'd1, "R10 count down", r, 32'd1);
    rd(4'd8, r); check(r == 32'h101, "R10 still busy", r, 32'h101);
    check(fd_cnt == fd0, "R10 no early frame_done", fd_cnt, fd0);
    wr(4'd6, 32'h0);
    wait_idle();
    rd(4'd1, r); check(r == 32'd0, "R10 count zero", r, 32'd0);
    rd(4'd8, r); check(r == 32'h1, "R10 busy cleared", r, 32'h1);
    check(fd_cnt == fd0 + 1, "R10 one frame_done", fd_cnt, fd0 + 1);

    // R9 config gating and disabled start
    wr(4'd9, 32'h4); wr(4'd10, 32'h4);
    wr(4'd1, 32'd1);
    wr(4'd0, 32'h11);
    rd(4'd8, r); check(r == 32'h1, "R9 config blocks start", r, 32'h1);
    wr(4'd10, 32'h8);
    wr(4'd0, 32'h11);
    rd(4'd8, r); check(r == 32'h101, "R9 disjoint config starts", r, 32'h101);
    fd0 = fd_cnt; base = nev;
    wr(4'd5, 32'h0);
    wait_idle();
    rd(4'd8, r); check(r == 32'h1, "R10 end with no chip", r, 32'h1);
    check(fd_cnt == fd0 + 1 && nev == base, "R6 R10 no cycle, frame_done", fd_cnt - fd0, 1);
    wr(4'd1, 32'd1);
    wr(4'd0, 32'h10);
    rd(4'd8, r); check(r == 32'h1, "R9 disabled start ignored", r, 32'h1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule